// File: doc/BRIEF.md
# I2C Host Register Front-End

This block is the byte-wide register face of an I2C master. A CPU reads and writes six byte registers: own address, clock divider, control, status, data and input filter. The block turns those accesses into byte-level commands for a separate bus engine: start with an address byte, send a byte, receive a byte, or stop. It takes the engine's ack or nack and any received byte, and from them it updates the status flags and a level interrupt. The divider and filter registers only hold values for the engine to use.

A transfer tracker decides what a write to the data register means. If no transfer is open, the write is an address phase. If a transfer is open, the write is a data phase. In master-receive mode, a read of the data register returns the byte already held and starts the next receive. Clearing the enable bit while the block is enabled performs a soft reset. Only one engine command is in flight at a time. Software polls the transfer-complete flag before its next access.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset, status (offset 0x0C) reads 0x81 and every other register reads 0x00. `irq` is low, `cmd_valid` is low and no transfer is open.
- R2: Writes are masked and read back as follows: own address 0x00 with 0xFE, divider 0x04 with 0x3F, control 0x08 with 0xFC, status 0x0C with 0xED, data 0x10 with 0xFF (while enabled), and filter 0x14 as the full byte. Reads of any other offset return 0x00.
- R3: `irq` is high exactly when control bit 7 (enable), control bit 6 (interrupt enable) and status bit 1 (interrupt flag) are all set. A status write always clears the interrupt flag.
- R4: Writing control with bit 7 clear while bit 7 is set resets every register to its reset value, except the own address, and discards the rest of that write.
- R5: A control write with bit 5 (master) set sets status bit 5 (bus busy). A control write with bit 5 clear clears bus busy. If a transfer is open, that write also issues STOP and closes the transfer.
- R6: A control write with bit 2 (repeated start) set, bit 5 set and a transfer open issues STOP, closes the transfer and leaves bit 2 clear. If no transfer is open, bit 2 is kept and no command is issued.
- R7: A data write while control bit 7 is clear leaves the data register unchanged and issues no command.
- R8: A data write in master mode with no transfer open issues START (op 0) carrying the byte, where bit 0 is the read/not-write flag. On ack, status bit 0 is cleared, bits 7 and 1 are set and the transfer opens. On nack, only status bit 0 is set and the transfer stays closed.
- R9: A data write in master mode with a transfer open issues SEND (op 1). On ack, status bit 0 is cleared and bits 7 and 1 are set. On nack, status bit 0 is set, STOP (op 3) follows at once and the transfer closes.
- R10: A data read with control bit 5 set and bit 4 clear returns the held byte and issues RECV (op 2). On success, the data register loads the received byte and status bits 7 and 1 are set. On failure, the data register loads 0xFF and the flags are unchanged.
- R11: `cmd_valid` stays high with a stable op and byte until `cmd_done`. CPU writes made while a command is pending are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | CPU access strobe, one cycle per access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Byte offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |
| cmd_valid | output | 1 | Engine command pending |
| cmd_op | output | 2 | 0 START, 1 SEND, 2 RECV, 3 STOP |
| cmd_data | output | 8 | Address or data byte for START and SEND |
| cmd_done | input | 1 | Engine finished the pending command |
| cmd_ok | input | 1 | Ack for START and SEND, success for RECV |
| cmd_rdata | input | 8 | Received byte, valid with `cmd_done` |

## Verification
The hardest case to reach from the ports is a nack on a data byte. Only an already opened transfer can produce one. The engine model must first ack a START, then nack the SEND, and then serve the STOP that the block chains on its own. Only after that does a further data write show that the transfer closed, because it comes out as a START again. Repeated start and master release are each driven both with a transfer open and with none open, so the STOP appears in one case and stays absent in the other. The receive path is driven with a succeeding engine and with a failing one.

// File: rtl/ihr_pkg.sv
package ihr_pkg;
  localparam int DW = 8;

  // register offsets
  localparam int OFS_OWN = 'h00;
  localparam int OFS_DIV = 'h04;
  localparam int OFS_CTL = 'h08;
  localparam int OFS_STS = 'h0C;
  localparam int OFS_DAT = 'h10;
  localparam int OFS_FLT = 'h14;

  // control bit positions
  localparam int CT_EN  = 7;
  localparam int CT_IE  = 6;
  localparam int CT_MST = 5;
  localparam int CT_TX  = 4;
  localparam int CT_RS  = 2;

  // status bit positions
  localparam int ST_DONE = 7;
  localparam int ST_BUSY = 5;
  localparam int ST_IF   = 1;
  localparam int ST_NACK = 0;

  localparam logic [DW-1:0] MSK_OWN = 8'hFE;
  localparam logic [DW-1:0] MSK_DIV = 8'h3F;
  localparam logic [DW-1:0] MSK_CTL = 8'hFC;
  localparam logic [DW-1:0] MSK_STS = 8'hED;

  localparam logic [DW-1:0] STS_RST  = 8'h81;
  localparam logic [DW-1:0] TRK_IDLE = 8'hFF;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } ihr_op_e;
endpackage

// File: rtl/ihr_rst_sync.sv
module ihr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/ihr_cmd_seq.sv
module ihr_cmd_seq
  import ihr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  ihr_op_e       launch_op,
  input  logic [DW-1:0] launch_byte,
  output logic          busy,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [DW-1:0] cmd_data,
  input  logic          cmd_done,
  input  logic          cmd_ok,
  input  logic [DW-1:0] cmd_rdata,
  output logic          ev_valid,
  output ihr_op_e       ev_op,
  output logic          ev_ok,
  output logic [DW-1:0] ev_rdata
);
  typedef enum logic {SQ_IDLE, SQ_WAIT} sq_e;

  sq_e           st_q, st_n;
  ihr_op_e       op_q, op_n;
  logic [DW-1:0] byte_q, byte_n;
  logic          ld;

  // next state: a nacked SEND chains a STOP without going idle
  always_comb begin
    st_n   = st_q;
    op_n   = op_q;
    byte_n = byte_q;
    ld     = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (launch) begin
          st_n   = SQ_WAIT;
          op_n   = launch_op;
          byte_n = launch_byte;
          ld     = 1'b1;
        end
      end
      SQ_WAIT: begin
        if (cmd_done) begin
          ld = 1'b1;
          if (op_q == OP_SEND && !cmd_ok) op_n = OP_STOP;
          else                            st_n = SQ_IDLE;
        end
      end
      default: begin
        st_n = SQ_IDLE;
        ld   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      op_q   <= OP_START;
      byte_q <= '0;
    end else if (ld) begin
      st_q   <= st_n;
      op_q   <= op_n;
      byte_q <= byte_n;
    end
  end

  assign busy      = (st_q == SQ_WAIT);
  assign cmd_valid = busy;
  assign cmd_op    = op_q;
  assign cmd_data  = byte_q;
  assign ev_valid  = busy && cmd_done;
  assign ev_op     = op_q;
  assign ev_ok     = cmd_ok;
  assign ev_rdata  = cmd_rdata;
endmodule

// File: rtl/ihr_rd_mux.sv
module ihr_rd_mux
  import ihr_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] own,
  input  logic [DW-1:0] div,
  input  logic [DW-1:0] ctl,
  input  logic [DW-1:0] sts,
  input  logic [DW-1:0] dat,
  input  logic [DW-1:0] flt,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] A_OWN = AW'(OFS_OWN);
  localparam logic [AW-1:0] A_DIV = AW'(OFS_DIV);
  localparam logic [AW-1:0] A_CTL = AW'(OFS_CTL);
  localparam logic [AW-1:0] A_STS = AW'(OFS_STS);
  localparam logic [AW-1:0] A_DAT = AW'(OFS_DAT);
  localparam logic [AW-1:0] A_FLT = AW'(OFS_FLT);

  always_comb begin
    case (addr)
      A_OWN:   rdata = own;
      A_DIV:   rdata = div;
      A_CTL:   rdata = ctl;
      A_STS:   rdata = sts;
      A_DAT:   rdata = dat;
      A_FLT:   rdata = flt;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import ihr_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          irq,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_data,
  input  logic          cmd_done,
  input  logic          cmd_ok,
  input  logic [7:0]    cmd_rdata
);
  localparam logic [AW-1:0] A_OWN = AW'(OFS_OWN);
  localparam logic [AW-1:0] A_DIV = AW'(OFS_DIV);
  localparam logic [AW-1:0] A_CTL = AW'(OFS_CTL);
  localparam logic [AW-1:0] A_STS = AW'(OFS_STS);
  localparam logic [AW-1:0] A_DAT = AW'(OFS_DAT);
  localparam logic [AW-1:0] A_FLT = AW'(OFS_FLT);

  logic rst_sn;

  logic [DW-1:0] own_q, div_q, ctl_q, sts_q, dat_q, flt_q, trk_q;
  logic [DW-1:0] own_n, div_n, ctl_n, sts_n, dat_n, flt_n, trk_n;

  logic          busy, launch, ev_valid, ev_ok;
  ihr_op_e       launch_op, ev_op;
  logic [DW-1:0] launch_byte, ev_rdata;
  logic          wr_acc, rd_acc, xfer_open;

  ihr_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_sn(rst_sn)
  );

  ihr_cmd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .launch     (launch),
    .launch_op  (launch_op),
    .launch_byte(launch_byte),
    .busy       (busy),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_data   (cmd_data),
    .cmd_done   (cmd_done),
    .cmd_ok     (cmd_ok),
    .cmd_rdata  (cmd_rdata),
    .ev_valid   (ev_valid),
    .ev_op      (ev_op),
    .ev_ok      (ev_ok),
    .ev_rdata   (ev_rdata)
  );

  ihr_rd_mux #(.AW(AW)) u_rd (
    .addr (cpu_addr),
    .own  (own_q),
    .div  (div_q),
    .ctl  (ctl_q),
    .sts  (sts_q),
    .dat  (dat_q),
    .flt  (flt_q),
    .rdata(cpu_rdata)
  );

  // accesses are honoured only while no engine command is pending
  assign wr_acc    = cpu_sel && cpu_wr && !busy;
  assign rd_acc    = cpu_sel && !cpu_wr && !busy;
  assign xfer_open = (trk_q != TRK_IDLE);

  always_comb begin
    own_n       = own_q;
    div_n       = div_q;
    ctl_n       = ctl_q;
    sts_n       = sts_q;
    dat_n       = dat_q;
    flt_n       = flt_q;
    trk_n       = trk_q;
    launch      = 1'b0;
    launch_op   = OP_STOP;
    launch_byte = dat_q;

    // engine completions
    if (ev_valid) begin
      case (ev_op)
        OP_START: begin
          if (ev_ok) begin
            trk_n          = dat_q;
            sts_n[ST_NACK] = 1'b0;
            sts_n[ST_DONE] = 1'b1;
            sts_n[ST_IF]   = 1'b1;
          end else begin
            sts_n[ST_NACK] = 1'b1;
          end
        end
        OP_SEND: begin
          if (ev_ok) begin
            sts_n[ST_NACK] = 1'b0;
            sts_n[ST_DONE] = 1'b1;
            sts_n[ST_IF]   = 1'b1;
          end else begin
            sts_n[ST_NACK] = 1'b1;
            trk_n          = TRK_IDLE;
          end
        end
        OP_RECV: begin
          if (ev_ok) begin
            dat_n          = ev_rdata;
            sts_n[ST_DONE] = 1'b1;
            sts_n[ST_IF]   = 1'b1;
          end else begin
            dat_n = 8'hFF;
          end
        end
        default: ;
      endcase
    end

    // CPU writes
    if (wr_acc) begin
      case (cpu_addr)
        A_OWN: own_n = cpu_wdata & MSK_OWN;
        A_DIV: div_n = cpu_wdata & MSK_DIV;
        A_FLT: flt_n = cpu_wdata;
        A_STS: sts_n = cpu_wdata & MSK_STS;
        A_CTL: begin
          if (ctl_q[CT_EN] && !cpu_wdata[CT_EN]) begin
            div_n = '0;
            ctl_n = '0;
            sts_n = STS_RST;
            dat_n = '0;
            flt_n = '0;
            trk_n = TRK_IDLE;
          end else begin
            ctl_n = cpu_wdata & MSK_CTL;
            if (cpu_wdata[CT_MST]) begin
              sts_n[ST_BUSY] = 1'b1;
              if (cpu_wdata[CT_RS] && xfer_open) begin
                launch       = 1'b1;
                trk_n        = TRK_IDLE;
                ctl_n[CT_RS] = 1'b0;
              end
            end else begin
              sts_n[ST_BUSY] = 1'b0;
              if (xfer_open) begin
                launch = 1'b1;
                trk_n  = TRK_IDLE;
              end
            end
          end
        end
        A_DAT: begin
          if (ctl_q[CT_EN]) begin
            dat_n = cpu_wdata;
            if (ctl_q[CT_MST]) begin
              launch      = 1'b1;
              launch_op   = xfer_open ? OP_SEND : OP_START;
              launch_byte = cpu_wdata;
            end
          end
        end
        default: ;
      endcase
    end

    // master-receive data read launches the next byte
    if (rd_acc && cpu_addr == A_DAT && ctl_q[CT_MST] && !ctl_q[CT_TX]) begin
      launch    = 1'b1;
      launch_op = OP_RECV;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      own_q <= '0;
      div_q <= '0;
      ctl_q <= '0;
      sts_q <= STS_RST;
      dat_q <= '0;
      flt_q <= '0;
      trk_q <= TRK_IDLE;
    end else begin
      own_q <= own_n;
      div_q <= div_n;
      ctl_q <= ctl_n;
      sts_q <= sts_n;
      dat_q <= dat_n;
      flt_q <= flt_n;
      trk_q <= trk_n;
    end
  end

  assign irq = ctl_q[CT_EN] && ctl_q[CT_IE] && sts_q[ST_IF];
endmodule

// File: rtl/ihr_chk.sv
module ihr_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          cpu_sel,
  input logic          cpu_wr,
  input logic [AW-1:0] cpu_addr,
  input logic          irq,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [7:0]    cmd_data,
  input logic          cmd_done,
  input logic          cmd_ok,
  input logic [7:0]    cmd_rdata,
  input logic [7:0]    own_q,
  input logic [7:0]    ctl_q,
  input logic [7:0]    dat_q
);
  localparam logic [AW-1:0] A_STS = AW'('h0C);
  localparam logic [AW-1:0] A_DAT = AW'('h10);

  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data));

  assert_busy_write_dropped_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid && !cmd_done && cpu_sel && cpu_wr |=> $stable(own_q));

  assert_sts_write_drops_irq_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    cpu_sel && cpu_wr && cpu_addr == A_STS && !cmd_valid |=> !irq);

  assert_nack_chains_stop_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid && cmd_op == 2'd1 && cmd_done && !cmd_ok |=> cmd_valid && cmd_op == 2'd3);

  assert_disabled_data_ignored_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    cpu_sel && cpu_wr && cpu_addr == A_DAT && !cmd_valid && !ctl_q[7]
    |=> !cmd_valid && $stable(dat_q));

  assert_recv_load_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid && cmd_op == 2'd2 && cmd_done
    |=> dat_q == ($past(cmd_ok) ? $past(cmd_rdata) : 8'hFF));
endmodule

bind i2c_host_regs ihr_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .cpu_sel  (cpu_sel),
  .cpu_wr   (cpu_wr),
  .cpu_addr (cpu_addr),
  .irq      (irq),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .cmd_data (cmd_data),
  .cmd_done (cmd_done),
  .cmd_ok   (cmd_ok),
  .cmd_rdata(cmd_rdata),
  .own_q    (own_q),
  .ctl_q    (ctl_q),
  .dat_q    (dat_q)
);

// File: tb/tb_i2c_host_regs.sv
module tb_i2c_host_regs;
  localparam int AW = 5;
  localparam int OP_START = 0, OP_SEND = 1, OP_RECV = 2, OP_STOP = 3;
  localparam int R_OWN = 'h00, R_DIV = 'h04, R_CTL = 'h08, R_STS = 'h0C, R_DAT = 'h10, R_FLT = 'h14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_sel, cpu_wr;
  logic [AW-1:0] cpu_addr;
  logic [7:0]    cpu_wdata, cpu_rdata;
  logic          irq, cmd_valid, cmd_done, cmd_ok;
  logic [1:0]    cmd_op;
  logic [7:0]    cmd_data, cmd_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_host_regs #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_done(cmd_done), .cmd_ok(cmd_ok), .cmd_rdata(cmd_rdata)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = AW'(a); cpu_wdata = 8'(d);
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = AW'(a);
    #1 d = int'(cpu_rdata);
    @(negedge clk);
    cpu_sel = 1'b0;
  endtask

  task automatic rd_chk(string req, string what, int a, int exp);
    int v;
    rd(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic reply(string req, int op, int byt, bit ok, int rx);
    int n = 0;
    while (!cmd_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(req, "cmd_valid", int'(cmd_valid), 1);
    chk(req, "cmd_op", int'(cmd_op), op);
    if (byt >= 0) chk(req, "cmd_data", int'(cmd_data), byt);
    cmd_done = 1'b1; cmd_ok = ok; cmd_rdata = 8'(rx);
    @(negedge clk);
    cmd_done = 1'b0; cmd_ok = 1'b0; cmd_rdata = 8'h00;
  endtask

  task automatic no_cmd(string req);
    @(negedge clk);
    chk(req, "no command", int'(cmd_valid), 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int v;
    rst_n = 1'b0; cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    cmd_done = 1'b0; cmd_ok = 1'b0; cmd_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk("R1", "own", R_OWN, 0);
    rd_chk("R1", "div", R_DIV, 0);
    rd_chk("R1", "ctl", R_CTL, 0);
    rd_chk("R1", "sts", R_STS, 'h81);
    rd_chk("R1", "dat", R_DAT, 0);
    rd_chk("R1", "flt", R_FLT, 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "cmd_valid", int'(cmd_valid), 0);

    // R2 write masks, swept over every byte value
    for (int i = 0; i < 256; i++) begin
      wr(R_OWN, i); rd_chk("R2", "own", R_OWN, i & 'hFE);
      wr(R_DIV, i); rd_chk("R2", "div", R_DIV, i & 'h3F);
      wr(R_FLT, i); rd_chk("R2", "flt", R_FLT, i);
      wr(R_STS, i); rd_chk("R2", "sts", R_STS, i & 'hED);
    end
    for (int i = 0; i < 128; i++) begin
      wr(R_CTL, i); rd_chk("R2", "ctl", R_CTL, i & 'hFC);
    end
    for (int a = 0; a < 32; a++) begin
      if (a != R_OWN && a != R_DIV && a != R_CTL && a != R_STS && a != R_DAT && a != R_FLT)
        rd_chk("R2", "unmapped", a, 0);
    end
    wr(R_CTL, 'h00);
    wr(R_STS, 'h81);

    // R7 data write while disabled
    wr(R_DAT, 'h5A);
    chk("R7", "no command", int'(cmd_valid), 0);
    rd_chk("R7", "dat", R_DAT, 0);

    // R2 data register, enabled slave-side (no commands)
    wr(R_CTL, 'h80);
    for (int i = 0; i < 256; i++) begin
      wr(R_DAT, i); rd_chk("R2", "dat", R_DAT, i);
    end
    chk("R2", "no command", int'(cmd_valid), 0);

    // R4 soft reset keeps own address, discards the write
    wr(R_OWN, 'h42); wr(R_DIV, 'h15); wr(R_FLT, 'h33); wr(R_STS, 'h00);
    wr(R_CTL, 'h60);
    rd_chk("R4", "own", R_OWN, 'h42);
    rd_chk("R4", "div", R_DIV, 0);
    rd_chk("R4", "flt", R_FLT, 0);
    rd_chk("R4", "ctl", R_CTL, 0);
    rd_chk("R4", "sts", R_STS, 'h81);
    rd_chk("R4", "dat", R_DAT, 0);

    // R5 master set raises bus busy; R8 address nack then ack
    wr(R_CTL, 'hF0);
    rd_chk("R5", "sts busy", R_STS, 'hA1);
    wr(R_STS, 'h00);
    wr(R_DAT, 'hA4);
    reply("R8", OP_START, 'hA4, 1'b0, 0);
    rd_chk("R8", "sts nack", R_STS, 'h01);
    chk("R8", "irq", int'(irq), 0);
    wr(R_DAT, 'hA4);
    reply("R8", OP_START, 'hA4, 1'b1, 0);
    rd_chk("R8", "sts ack", R_STS, 'h82);
    chk("R3", "irq set", int'(irq), 1);

    // R11 command held, writes during pending dropped; R9 send ack
    wr(R_DAT, 'h11);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11", "held valid", int'(cmd_valid), 1);
      chk("R11", "held op", int'(cmd_op), OP_SEND);
      chk("R11", "held byte", int'(cmd_data), 'h11);
    end
    wr(R_OWN, 'h99);
    reply("R9", OP_SEND, 'h11, 1'b1, 0);
    rd_chk("R11", "own untouched", R_OWN, 'h42);
    rd_chk("R9", "sts ack", R_STS, 'h82);

    // R3 status write clears flag; gating by interrupt enable
    wr(R_STS, 'h00);
    chk("R3", "irq after sts write", int'(irq), 0);
    wr(R_DAT, 'h22);
    reply("R9", OP_SEND, 'h22, 1'b1, 0);
    chk("R3", "irq again", int'(irq), 1);
    wr(R_CTL, 'hB0);
    chk("R3", "irq gated", int'(irq), 0);
    rd_chk("R5", "sts", R_STS, 'hA2);
    wr(R_CTL, 'hF0);
    chk("R3", "irq ungated", int'(irq), 1);

    // R9 data nack chains stop, transfer closes
    wr(R_DAT, 'h33);
    reply("R9", OP_SEND, 'h33, 1'b0, 0);
    reply("R9", OP_STOP, -1, 1'b1, 0);
    rd_chk("R9", "sts nack", R_STS, 'hA3);
    wr(R_DAT, 'h44);
    reply("R9", OP_START, 'h44, 1'b1, 0);
    rd_chk("R9", "sts", R_STS, 'hA2);

    // R6 repeated start with and without an open transfer
    wr(R_CTL, 'hF4);
    reply("R6", OP_STOP, -1, 1'b1, 0);
    rd_chk("R6", "rs cleared", R_CTL, 'hF0);
    wr(R_CTL, 'hF4);
    no_cmd("R6");
    rd_chk("R6", "rs kept", R_CTL, 'hF4);
    wr(R_CTL, 'hF0);

    // R5 master release stops an open transfer
    wr(R_DAT, 'h45);
    reply("R5", OP_START, 'h45, 1'b1, 0);
    wr(R_CTL, 'hC0);
    reply("R5", OP_STOP, -1, 1'b1, 0);
    rd_chk("R5", "busy cleared", R_STS, 'h82);
    wr(R_CTL, 'hC0);
    no_cmd("R5");

    // R10 receive success and failure
    wr(R_CTL, 'hF0);
    wr(R_DAT, 'h51);
    reply("R10", OP_START, 'h51, 1'b1, 0);
    wr(R_CTL, 'hE0);
    wr(R_STS, 'h00);
    rd(R_DAT, v);
    chk("R10", "held byte", v, 'h51);
    reply("R10", OP_RECV, -1, 1'b1, 'h6C);
    rd_chk("R10", "sts", R_STS, 'h82);
    wr(R_CTL, 'hF0);
    rd_chk("R10", "rx byte", R_DAT, 'h6C);
    no_cmd("R10");
    wr(R_CTL, 'hE0);
    wr(R_STS, 'h00);
    rd(R_DAT, v);
    chk("R10", "held byte 2", v, 'h6C);
    reply("R10", OP_RECV, -1, 1'b0, 'h12);
    rd_chk("R10", "sts fail", R_STS, 'h00);
    wr(R_CTL, 'hF0);
    rd_chk("R10", "fail byte", R_DAT, 'hFF);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule